// File: doc/BRIEF.md
# Management Frame PHY Register Bridge

This block sits between a 32-bit management control register, written by a host, and the register ports of two PHY register banks: a local one and an optional secondary one. A host write to the control register is decoded into an operation (read or write), a PHY address, a register number and 16 bits of write data. The access is then carried out on the register port of the PHY that the address selects. Serial bit shifting and clock division are not part of this block. The PHY banks are plain synchronous register ports with a request/acknowledge pair.

A read places the PHY's answer in the low half of the stored control word and leaves the upper half as written. Every access ends by setting a management-done event bit, whether or not a PHY was reached. The host clears that bit by writing a one to it. If the PHY link is configured as disconnected, or the address matches no PHY, the access completes at once: a read returns all ones and a write is dropped. The local PHY number, the secondary PHY number and the secondary-present flag are static configuration inputs.

Top module: `mgmt_phy_bridge`

## Requirements
- R1: After synchronous reset, `ctrl_q` is 0, `busy` is 0, `mgmt_done` is 0, and neither PHY port requests.
- R2: Bit 29 of a control word written with `host_sel_evt`=0 selects the operation: 1 is a read and 0 is a write. Only a write issues `*_we`=1 on the PHY port.
- R3: Bits 27:23 of the control word are the PHY address and bits 22:18 are the register number. The register number appears on the selected port's `*_reg` output.
- R4: For a write, bits 15:0 of the control word are presented on the selected port's `*_wdata` and are stored in that PHY register.
- R5: For a read, `ctrl_q[15:0]` takes the PHY's returned data, and `ctrl_q[31:16]` keeps the written value.
- R6: With `cfg_phy_connected`=0, a read returns 0xFFFF in `ctrl_q[15:0]` and a write changes no PHY register. No port request is made.
- R7: An address equal to `cfg_sec_addr`, with `cfg_sec_present`=1 and not equal to `cfg_local_addr`, goes to the secondary port. At most one port requests at a time.
- R8: An address matching neither PHY reads 0xFFFF and discards a write, with no port request.
- R9: Every accepted control write sets `mgmt_done`: a hit sets it when the port acknowledges, and a miss sets it in the cycle after the write.
- R10: A host write with `host_sel_evt`=1 and bit 0 of the data set clears `mgmt_done`. The same write with bit 0 clear leaves it unchanged.
- R11: `busy` is high from an accepted write that hits a PHY until the cycle after the port acknowledge. Control writes while `busy` is high are ignored and change neither `ctrl_q` nor any PHY register.
- R12: When the address equals both the local and the secondary number, the local port is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_phy_connected | input | 1 | PHY link present |
| cfg_local_addr | input | 5 | Local PHY number |
| cfg_sec_present | input | 1 | Secondary PHY present |
| cfg_sec_addr | input | 5 | Secondary PHY number |
| host_wr | input | 1 | Host write strobe |
| host_sel_evt | input | 1 | 0: control register, 1: event register |
| host_wdata | input | 32 | Host write data |
| ctrl_q | output | 32 | Stored control word |
| busy | output | 1 | PHY access in flight |
| mgmt_done | output | 1 | Management-done event bit |
| loc_req | output | 1 | Local port request |
| loc_we | output | 1 | Local port write enable |
| loc_reg | output | 5 | Local port register number |
| loc_wdata | output | 16 | Local port write data |
| loc_ack | input | 1 | Local port acknowledge |
| loc_rdata | input | 16 | Local port read data |
| sec_req | output | 1 | Secondary port request |
| sec_we | output | 1 | Secondary port write enable |
| sec_reg | output | 5 | Secondary port register number |
| sec_wdata | output | 16 | Secondary port write data |
| sec_ack | input | 1 | Secondary port acknowledge |
| sec_rdata | input | 16 | Secondary port read data |

## Verification
The bench targets these corner cases:
- Disconnected link, unmatched addresses and an absent secondary PHY. A design that still issued requests here would corrupt the bench's PHY banks, and a later readback would show it.
- A local number equal to the secondary number. A design with the priority reversed would send the access to the wrong bank.
- A second control write landed while an access is in flight. A design that accepted it would overwrite the captured word or issue a second request.
- An event write with bit 0 clear. A design with write-to-clear semantics instead of write-one-to-clear would lose the done flag.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    parameter int CTRL_W   = 32;
    parameter int DATA_W   = 16;
    parameter int ADDR_W   = 5;
    parameter int OP_BIT   = 29;
    parameter int TGT_LSB  = 18;
    parameter int DONE_BIT = 0;
    localparam int REG_LSB = TGT_LSB;
    localparam int PHY_LSB = TGT_LSB + ADDR_W;

    typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} mgmt_op_e;
    typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_LOCAL = 2'd1, TGT_SEC = 2'd2} mgmt_tgt_e;

    typedef struct packed {
        mgmt_op_e            op;
        logic [ADDR_W-1:0]   phy;
        logic [ADDR_W-1:0]   regn;
        logic [DATA_W-1:0]   wdata;
    } mgmt_frame_t;

    function automatic mgmt_frame_t unpack_frame(input logic [CTRL_W-1:0] w);
        mgmt_frame_t f;
        f.op    = mgmt_op_e'(w[OP_BIT]);
        f.phy   = w[PHY_LSB +: ADDR_W];
        f.regn  = w[REG_LSB +: ADDR_W];
        f.wdata = w[DATA_W-1:0];
        return f;
    endfunction
endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
    import mgmt_pkg::*;
(
    input  logic [CTRL_W-1:0] word,
    output mgmt_frame_t       frame
);
    always_comb frame = unpack_frame(word);
endmodule

// File: rtl/mgmt_target_sel.sv
module mgmt_target_sel
    import mgmt_pkg::*;
(
    input  logic              connected,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic              sec_present,
    input  logic [ADDR_W-1:0] sec_addr,
    input  logic [ADDR_W-1:0] phy_addr,
    output mgmt_tgt_e         tgt
);
    always_comb begin
        tgt = TGT_NONE;
        if (connected) begin
            if (phy_addr == local_addr)                    tgt = TGT_LOCAL;
            else if (sec_present && phy_addr == sec_addr)  tgt = TGT_SEC;
        end
    end
endmodule

// File: rtl/mgmt_done_evt.sv
module mgmt_done_evt (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic done
);
    always_ff @(posedge clk) begin
        if (rst)      done <= 1'b0;
        else if (set) done <= 1'b1;
        else if (clr) done <= 1'b0;
    end

    // R9
    done_after_set_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> done);
    // R10
    done_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> done);
endmodule

// File: rtl/mgmt_phy_bridge.sv
module mgmt_phy_bridge
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_phy_connected,
    input  logic [ADDR_W-1:0] cfg_local_addr,
    input  logic              cfg_sec_present,
    input  logic [ADDR_W-1:0] cfg_sec_addr,
    input  logic              host_wr,
    input  logic              host_sel_evt,
    input  logic [CTRL_W-1:0] host_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              busy,
    output logic              mgmt_done,
    output logic              loc_req,
    output logic              loc_we,
    output logic [ADDR_W-1:0] loc_reg,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_ack,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              sec_req,
    output logic              sec_we,
    output logic [ADDR_W-1:0] sec_reg,
    output logic [DATA_W-1:0] sec_wdata,
    input  logic              sec_ack,
    input  logic [DATA_W-1:0] sec_rdata
);
    localparam int NPORT = 2;

    mgmt_frame_t dec, act_q;
    mgmt_tgt_e   tgt, act_tgt_q;

    mgmt_frame_decode u_dec (.word(host_wdata), .frame(dec));

    mgmt_target_sel u_sel (
        .connected  (cfg_phy_connected),
        .local_addr (cfg_local_addr),
        .sec_present(cfg_sec_present),
        .sec_addr   (cfg_sec_addr),
        .phy_addr   (dec.phy),
        .tgt        (tgt)
    );

    logic              ctrl_fire, hit, done_set, done_clr;
    logic [NPORT-1:0]  req_vec, ack_vec;
    logic [DATA_W-1:0] rdata_arr [NPORT];
    logic              ack_sel;
    logic [DATA_W-1:0] rdata_sel;

    assign ctrl_fire = host_wr && !host_sel_evt && !busy;
    assign hit       = (tgt != TGT_NONE);

    assign ack_vec      = {sec_ack, loc_ack};
    assign rdata_arr[0] = loc_rdata;
    assign rdata_arr[1] = sec_rdata;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam mgmt_tgt_e MY_TGT = (g == 0) ? TGT_LOCAL : TGT_SEC;
        assign req_vec[g] = busy && (act_tgt_q == MY_TGT);
    end

    always_comb begin
        ack_sel   = 1'b0;
        rdata_sel = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (req_vec[i]) begin
                ack_sel   = ack_vec[i];
                rdata_sel = rdata_arr[i];
            end
        end
    end

    assign loc_req   = req_vec[0];
    assign sec_req   = req_vec[1];
    assign loc_we    = req_vec[0] && (act_q.op == OP_WRITE);
    assign sec_we    = req_vec[1] && (act_q.op == OP_WRITE);
    assign loc_reg   = act_q.regn;
    assign sec_reg   = act_q.regn;
    assign loc_wdata = act_q.wdata;
    assign sec_wdata = act_q.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            busy      <= 1'b0;
            act_q     <= '0;
            act_tgt_q <= TGT_NONE;
        end else if (ctrl_fire) begin
            act_q     <= dec;
            act_tgt_q <= tgt;
            busy      <= hit;
            if (dec.op == OP_READ && !hit)
                ctrl_q <= {host_wdata[CTRL_W-1:DATA_W], {DATA_W{1'b1}}};
            else
                ctrl_q <= host_wdata;
        end else if (busy && ack_sel) begin
            busy <= 1'b0;
            if (act_q.op == OP_READ) ctrl_q[DATA_W-1:0] <= rdata_sel;
        end
    end

    assign done_set = (ctrl_fire && !hit) || (busy && ack_sel);
    assign done_clr = host_wr && host_sel_evt && host_wdata[DONE_BIT];

    mgmt_done_evt u_evt (
        .clk (clk),
        .rst (rst),
        .set (done_set),
        .clr (done_clr),
        .done(mgmt_done)
    );

    // R7
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loc_req, sec_req}));
    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !loc_ack && !sec_ack) |=> ($stable(ctrl_q) && busy));
    // R5
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (loc_ack || sec_ack)) |=> $stable(ctrl_q[CTRL_W-1:DATA_W]));
    // R6
    disc_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_phy_connected && !busy) |=> (!loc_req && !sec_req));
    // R9
    fall_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> mgmt_done);
endmodule

// File: tb/mgmt_phy_bridge_bench.sv
`timescale 1ns/1ps
module mgmt_phy_bridge_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_phy_connected, cfg_sec_present;
    logic [4:0]  cfg_local_addr, cfg_sec_addr;
    logic        host_wr, host_sel_evt;
    logic [31:0] host_wdata;
    logic [31:0] ctrl_q;
    logic        busy, mgmt_done;
    logic        loc_req, loc_we, sec_req, sec_we;
    logic [4:0]  loc_reg, sec_reg;
    logic [15:0] loc_wdata, sec_wdata;
    logic        loc_ack = 1'b0, sec_ack = 1'b0;
    logic [15:0] loc_rdata = '0, sec_rdata = '0;

    int tests = 0, fails = 0;
    int loc_acks = 0, sec_acks = 0;
    logic [15:0] m0 [32];
    logic [15:0] m1 [32];
    logic [15:0] e0 [32];
    logic [15:0] e1 [32];

    always #2 clk = ~clk;

    mgmt_phy_bridge u_mgmt_phy_bridge (.*);

    // PHY bank models: one-cycle acknowledge
    always @(posedge clk) begin
        if (loc_req && !loc_ack) begin
            loc_ack   <= 1'b1;
            loc_rdata <= m0[loc_reg];
            if (loc_we) m0[loc_reg] <= loc_wdata;
            loc_acks  <= loc_acks + 1;
        end else loc_ack <= 1'b0;
        if (sec_req && !sec_ack) begin
            sec_ack   <= 1'b1;
            sec_rdata <= m1[sec_reg];
            if (sec_we) m1[sec_reg] <= sec_wdata;
            sec_acks  <= sec_acks + 1;
        end else sec_ack <= 1'b0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 local, 1 secondary, 2 none
    function automatic int exp_tgt(input logic [4:0] a);
        if (!cfg_phy_connected) return 2;
        if (a == cfg_local_addr) return 0;
        if (cfg_sec_present && a == cfg_sec_addr) return 1;
        return 2;
    endfunction

    function automatic logic [31:0] mkword(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                                           input logic [15:0] d, input logic [31:0] noise);
        logic [31:0] w;
        w = noise;
        w[29] = rd;
        w[27:23] = pa;
        w[22:18] = ra;
        w[15:0] = d;
        return w;
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    endtask

    task automatic clear_done(input string req);
        host_wr = 1; host_sel_evt = 1; host_wdata = 32'h1;
        @(negedge clk);
        host_wr = 0; host_sel_evt = 0;
        chk(mgmt_done == 1'b0, req, {31'b0, mgmt_done}, 32'h0);
    endtask

    // full access with checks of ctrl, done, port choice and expected model
    task automatic do_op(input logic [31:0] w, input string req);
        int t, la, sa;
        logic [15:0] exp_lo;
        logic [31:0] exp_ctrl;
        t = exp_tgt(w[27:23]);
        la = loc_acks; sa = sec_acks;
        exp_lo = (t == 0) ? e0[w[22:18]] : (t == 1) ? e1[w[22:18]] : 16'hFFFF;
        exp_ctrl = w[29] ? {w[31:16], exp_lo} : w;
        if (!w[29]) begin
            if (t == 0) e0[w[22:18]] = w[15:0];
            if (t == 1) e1[w[22:18]] = w[15:0];
        end
        host_wr = 1; host_sel_evt = 0; host_wdata = w;
        @(negedge clk);
        host_wr = 0;
        wait_idle();
        chk(ctrl_q == exp_ctrl, req, ctrl_q, exp_ctrl);
        chk(mgmt_done == 1'b1, {req, " R9"}, {31'b0, mgmt_done}, 32'h1);
        chk((loc_acks - la) == (t == 0 ? 1 : 0) && (sec_acks - sa) == (t == 1 ? 1 : 0),
            {req, " R7 port choice"}, 32'(loc_acks - la) << 4 | 32'(sec_acks - sa),
            (t == 0 ? 32'h10 : t == 1 ? 32'h1 : 32'h0));
        clear_done("R10");
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) begin
            m0[i] = 16'h1000 + 16'(i * 7);
            m1[i] = 16'h2000 + 16'(i * 13);
            e0[i] = m0[i];
            e1[i] = m1[i];
        end
        cfg_phy_connected = 1; cfg_sec_present = 1;
        cfg_local_addr = 5'd3; cfg_sec_addr = 5'd9;
        host_wr = 0; host_sel_evt = 0; host_wdata = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(ctrl_q == 0 && !busy && !mgmt_done && !loc_req && !sec_req, "R1 reset",
            {ctrl_q[27:0], busy, mgmt_done, loc_req, sec_req}, 32'h0);

        // R2 R3 R4 local write then read back
        do_op(mkword(0, 5'd3, 5'd5, 16'hBEEF, 32'hC000_0000), "R4 local write");
        do_op(mkword(1, 5'd3, 5'd5, 16'h0000, 32'h5000_0000), "R2 R3 R5 local read");
        // R7 secondary
        do_op(mkword(0, 5'd9, 5'd17, 16'h1234, 32'h0), "R7 sec write");
        do_op(mkword(1, 5'd9, 5'd17, 16'h0, 32'hA000_0000), "R7 sec read");
        // R8 unmatched
        do_op(mkword(0, 5'd20, 5'd5, 16'h7777, 32'h0), "R8 miss write");
        do_op(mkword(1, 5'd20, 5'd5, 16'h0, 32'h4000_0000), "R8 miss read");
        do_op(mkword(1, 5'd3, 5'd5, 16'h0, 32'h0), "R8 local unchanged");
        // R6 disconnected
        cfg_phy_connected = 0;
        do_op(mkword(0, 5'd3, 5'd6, 16'h4444, 32'h0), "R6 disc write");
        do_op(mkword(1, 5'd3, 5'd6, 16'h0, 32'h0), "R6 disc read");
        cfg_phy_connected = 1;
        do_op(mkword(1, 5'd3, 5'd6, 16'h0, 32'h0), "R6 write dropped");
        // secondary absent
        cfg_sec_present = 0;
        do_op(mkword(1, 5'd9, 5'd1, 16'h0, 32'h0), "R8 sec absent");
        cfg_sec_present = 1;
        // R12 local priority
        cfg_sec_addr = 5'd3;
        do_op(mkword(0, 5'd3, 5'd8, 16'h5A5A, 32'h0), "R12 priority write");
        do_op(mkword(1, 5'd3, 5'd8, 16'h0, 32'h0), "R12 priority read");
        cfg_sec_addr = 5'd9;

        // R11 write during busy ignored
        begin
            int la;
            logic [31:0] wa;
            la = loc_acks;
            wa = mkword(1, 5'd3, 5'd5, 16'h0, 32'h8000_0000);
            host_wr = 1; host_sel_evt = 0; host_wdata = wa;
            @(negedge clk);
            chk(busy == 1'b1, "R11 busy high", {31'b0, busy}, 32'h1);
            host_wdata = mkword(0, 5'd3, 5'd5, 16'hDEAD, 32'h0);
            @(negedge clk);
            host_wr = 0;
            wait_idle();
            chk(ctrl_q == {wa[31:16], e0[5]}, "R11 ignored write", ctrl_q, {wa[31:16], e0[5]});
            chk(loc_acks - la == 1, "R11 single access", 32'(loc_acks - la), 32'h1);
            // R10 write with bit0 clear keeps done
            host_wr = 1; host_sel_evt = 1; host_wdata = 32'hFFFF_FFFE;
            @(negedge clk);
            host_wr = 0;
            chk(mgmt_done == 1'b1, "R10 bit0 clear keeps", {31'b0, mgmt_done}, 32'h1);
            clear_done("R10 clear");
            do_op(mkword(1, 5'd3, 5'd5, 16'h0, 32'h0), "R11 reg unchanged");
        end

        // random mix
        for (int n = 0; n < 150; n++) begin
            logic [4:0] pa;
            int sel;
            sel = int'($urandom % 4);
            pa = (sel == 0) ? 5'd3 : (sel == 1) ? 5'd9 : 5'($urandom);
            cfg_phy_connected = ($urandom % 8) != 0;
            do_op(mkword(1'($urandom), pa, 5'($urandom), 16'($urandom), $urandom),
                  "R2 R3 R4 R5 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule